// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets on-chip logic use an external asynchronous static RAM of 32K bytes through a simple synchronous request port. A requester offers a read or a write with a valid/ready handshake. The controller then runs the memory's active-low chip-enable, output-enable and write-enable strobes, presents the address, and drives or samples the shared 8-bit data bus. A completed read returns its byte together with a one-cycle valid strobe.

Every timing limit of the memory is a parameter counted in whole system clock cycles. Each one is forced to at least one cycle. A single phase counter sequences the states IDLE, READ_ACCESS, WRITE_SETUP, WRITE_PULSE, WRITE_HOLD and TURNAROUND. These are the transitions:

- IDLE to READ_ACCESS or WRITE_SETUP when a request is accepted.
- READ_ACCESS to TURNAROUND when the access count expires.
- TURNAROUND to IDLE once the read cycle time is met.
- WRITE_SETUP to WRITE_PULSE once the setup count has expired and the bus is free.
- WRITE_PULSE to WRITE_HOLD after the pulse width.
- WRITE_HOLD to IDLE after the hold and write cycle time.

A separate guard counts the cycles since output enable was last released. The controller does not drive the bus until the memory has had time to let go of it.

The memory side is presented as a split view of the bidirectional bus: data out, data in and a drive enable. The pad cell lies outside this block. A build-time mode decides whether output enable stays high during a write or is held low across the write pulse. Each mode has its own minimum pulse width.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is accepted only at a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 1 only in IDLE. While the controller is busy, changes on `req_valid`, `req_write`, `req_addr` and `req_wdata` do not alter `mem_addr` or the value written.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with the request address for exactly ACCESS_CYC cycles. The byte on `mem_dq_in` at the end of the last of those cycles goes to `rsp_rdata`. `rsp_valid` is 1 for exactly one cycle, and in that cycle `mem_ce_n` and `mem_oe_n` are already 1.
- R4: With OE_LOW_IN_WRITE=0, each write pulls `mem_we_n` low for exactly WPULSE_OEHI_CYC cycles, keeps `mem_oe_n` at 1 for the whole write, and keeps `mem_ce_n` low around the pulse.
- R5: `mem_addr` and `mem_dq_out` stay constant while `mem_we_n` is low. With OE_LOW_IN_WRITE=0, `mem_dq_oe` is 1 for the whole pulse. `mem_dq_oe` and chip enable both stay asserted in the cycle after `mem_we_n` returns high, and for DATA_HOLD_CYC cycles in all.
- R6: `mem_dq_oe` never rises until `mem_oe_n` has been 1 for at least TURN_CYC full cycles, and it is never 1 while a read has the memory driving.
- R7: The chip-enable-low period of a write lasts at least WRITE_CYCLE_CYC cycles. Two read starts are at least READ_CYCLE_CYC cycles apart.
- R8: With OE_LOW_IN_WRITE=1, `mem_oe_n` is low during the write pulse, which lasts max(WPULSE_OELO_CYC, WE_HIZ_CYC+1) cycles. `mem_dq_oe` is 1 only inside the pulse, and only after its first WE_HIZ_CYC cycles.
- R9: `rsp_rdata` keeps its value until the next read completes.
- R10: A read returns the byte last written to that address. This includes the lowest address 0x0000 and the highest address 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read completion strobe |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Data to drive onto the bus |
| mem_dq_in | input | DATA_W | Data seen on the bus |
| mem_dq_oe | output | 1 | Controller drives the bus when 1 |

## Verification
The bench goes after a write issued straight after a read, where the memory is still releasing the bus. A controller with a short or missing turnaround would drive against the memory model's output tail. It also measures every write-enable pulse in both output-enable modes. A controller that used the wrong width, or drove data before the memory's write-enable-to-high-impedance delay, shows up as a width mismatch or a drive outside the allowed window. Requests changed while the controller is busy, and reads from the highest and lowest address, catch a design that latches inputs late or drops address bits. The read sample point is checked against a model that returns valid data only after the access count, so sampling one cycle early returns a wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_ACCESS,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_HOLD,
        ST_TURNAROUND
    } ctrl_state_e;

    // a timing limit in cycles is never allowed below one
    function automatic int at_least_one(int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    // down-counter: loaded on state entry, stops at zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/sram_bus_guard.sv
module sram_bus_guard #(
    parameter int TURN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic bus_free
);

    localparam int CW = $clog2(TURN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TURN);

    logic [CW-1:0] since_release;

    // counts cycles with output enable high, saturating at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_release <= LIMIT;
        end else if (!oe_n) begin
            since_release <= '0;
        end else if (since_release < LIMIT) begin
            since_release <= since_release + 1'b1;
        end
    end

    assign bus_free = (since_release >= LIMIT);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic              strobe,
    output logic [DATA_W-1:0] held
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            held   <= '0;
        end else begin
            strobe <= capture;
            if (capture) begin
                held <= bus_in;
            end
        end
    end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W          = 15,
    parameter int DATA_W          = 8,
    parameter int ACCESS_CYC      = 2,
    parameter int READ_CYCLE_CYC  = 4,
    parameter int ADDR_SETUP_CYC  = 1,
    parameter int WPULSE_OEHI_CYC = 2,
    parameter int WPULSE_OELO_CYC = 3,
    parameter int WE_HIZ_CYC      = 1,
    parameter int DATA_HOLD_CYC   = 1,
    parameter int WRITE_CYCLE_CYC = 4,
    parameter int TURN_CYC        = 4,
    parameter bit OE_LOW_IN_WRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    // phase lengths in cycles
    localparam int RD_LEN  = at_least_one(ACCESS_CYC);
    localparam int TR_LEN  = at_least_one(READ_CYCLE_CYC - RD_LEN);
    localparam int SU_LEN  = at_least_one(ADDR_SETUP_CYC);
    localparam int HIZ_LEN = at_least_one(WE_HIZ_CYC);
    localparam int WP_LEN  = OE_LOW_IN_WRITE ?
                             max2(at_least_one(WPULSE_OELO_CYC), HIZ_LEN + 1) :
                             at_least_one(WPULSE_OEHI_CYC);
    localparam int HD_LEN  = max2(at_least_one(DATA_HOLD_CYC),
                                  WRITE_CYCLE_CYC - SU_LEN - WP_LEN);
    localparam int TURN_LEN = at_least_one(TURN_CYC);
    localparam int MAX_LEN = max2(max2(RD_LEN, TR_LEN),
                                  max2(max2(SU_LEN, WP_LEN), HD_LEN));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    ctrl_state_e       state_q, state_nxt;
    logic [CNT_W-1:0]  phase_cnt;
    logic [CNT_W-1:0]  phase_load_val;
    logic              phase_load;
    logic              phase_done;
    logic              bus_free;
    logic              accept;
    logic              capture;
    logic              drive_en;
    logic [DATA_W-1:0] wdata_q;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign phase_done = (phase_cnt == '0);
    assign capture    = (state_q == ST_READ_ACCESS) && phase_done;

    // next-state decision
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_nxt = req_write ? ST_WRITE_SETUP : ST_READ_ACCESS;
                end
            end
            ST_READ_ACCESS: if (phase_done)             state_nxt = ST_TURNAROUND;
            ST_TURNAROUND:  if (phase_done)             state_nxt = ST_IDLE;
            ST_WRITE_SETUP: if (phase_done && bus_free) state_nxt = ST_WRITE_PULSE;
            ST_WRITE_PULSE: if (phase_done)             state_nxt = ST_WRITE_HOLD;
            ST_WRITE_HOLD:  if (phase_done)             state_nxt = ST_IDLE;
            default:                                    state_nxt = ST_IDLE;
        endcase
    end

    // phase counter reload on every state change
    always_comb begin
        phase_load = (state_nxt != state_q);
        unique case (state_nxt)
            ST_READ_ACCESS: phase_load_val = CNT_W'(RD_LEN - 1);
            ST_TURNAROUND:  phase_load_val = CNT_W'(TR_LEN - 1);
            ST_WRITE_SETUP: phase_load_val = CNT_W'(SU_LEN - 1);
            ST_WRITE_PULSE: phase_load_val = CNT_W'(WP_LEN - 1);
            ST_WRITE_HOLD:  phase_load_val = CNT_W'(HD_LEN - 1);
            default:        phase_load_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // registered strobes, address and write data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_addr <= '0;
            wdata_q  <= '0;
        end else begin
            mem_ce_n <= (state_nxt == ST_IDLE) || (state_nxt == ST_TURNAROUND);
            mem_oe_n <= !((state_nxt == ST_READ_ACCESS) ||
                          (OE_LOW_IN_WRITE && (state_nxt == ST_WRITE_PULSE)));
            mem_we_n <= (state_nxt != ST_WRITE_PULSE);
            if (accept) begin
                mem_addr <= req_addr;
                wdata_q  <= req_wdata;
            end
        end
    end

    // data drive window depends on the output-enable mode
    generate
        if (OE_LOW_IN_WRITE) begin : g_drive_oe_low
            // memory may still drive for HIZ_LEN cycles after the strobe falls
            localparam int DRIVE_FROM = WP_LEN - 1 - HIZ_LEN;
            assign drive_en = (state_q == ST_WRITE_PULSE) &&
                              (int'(phase_cnt) <= DRIVE_FROM);
        end else begin : g_drive_oe_high
            assign drive_en = ((state_q == ST_WRITE_SETUP) && bus_free) ||
                              (state_q == ST_WRITE_PULSE) ||
                              (state_q == ST_WRITE_HOLD);
        end
    endgenerate

    assign mem_dq_oe  = drive_en;
    assign mem_dq_out = wdata_q;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_load_val),
        .count    (phase_cnt)
    );

    sram_bus_guard #(
        .TURN (TURN_LEN)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (mem_oe_n),
        .bus_free (bus_free)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .bus_in  (mem_dq_in),
        .strobe  (rsp_valid),
        .held    (rsp_rdata)
    );

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
    parameter int ADDR_W          = 15,
    parameter int DATA_W          = 8,
    parameter bit OE_LOW_IN_WRITE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    p_rvalid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rvalid_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_ce_n && mem_oe_n));

    p_write_oe_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n == !OE_LOW_IN_WRITE));

    p_we_under_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    p_pulse_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && mem_we_n) |-> !mem_dq_oe);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
    .ADDR_W          (ADDR_W),
    .DATA_W          (DATA_W),
    .OE_LOW_IN_WRITE (OE_LOW_IN_WRITE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_model.sv
module sram_model #(
    parameter int ACC = 2,
    parameter int HZ  = 4
) (
    input  logic        clk,
    input  logic [14:0] addr,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [7:0]  din,
    input  logic        din_en,
    output logic [7:0]  dout,
    output logic        drv
);

    logic [7:0]  mem [int];
    int          stable_cyc = 0;
    int          since_rd   = 15;
    logic [14:0] a_last     = '0;
    bit          was_ov     = 1'b0;
    bit          data_ok    = 1'b0;
    logic [7:0]  last_d     = '0;
    logic [14:0] wr_a       = '0;
    logic        rd_en;

    function automatic logic [7:0] seed_val(logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    assign rd_en = !ce_n && !oe_n && we_n;

    always @(posedge clk) begin
        if (!rd_en)            stable_cyc <= 0;
        else if (addr != a_last) stable_cyc <= 1;
        else                   stable_cyc <= stable_cyc + 1;
        a_last <= addr;
        if (rd_en)             since_rd <= 0;
        else if (since_rd < 15) since_rd <= since_rd + 1;
        if (!ce_n && !we_n) begin
            was_ov  <= 1'b1;
            wr_a    <= addr;
            data_ok <= din_en;
            last_d  <= din;
        end else if (was_ov) begin
            mem[int'(wr_a)] = data_ok ? last_d : 8'hBD;
            was_ov <= 1'b0;
        end
    end

    always @* begin
        drv = rd_en || (since_rd < HZ);
        if (rd_en && (stable_cyc + 1 >= ACC))
            dout = mem.exists(int'(addr)) ? mem[int'(addr)] : seed_val(addr);
        else
            dout = 8'hEE;
    end

endmodule

// File: tb/async_sram_ctrl_test.sv
module async_sram_ctrl_test;

    localparam int ACC = 2, RCYC = 4, WPH = 2, WPL = 3, HIZ = 1, DHOLD = 1;
    localparam int WCYC = 4, TURN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 1'b0;

    // main instance: output enable high during writes
    logic req_valid = 0, req_write = 0, req_ready, rsp_valid;
    logic [14:0] req_addr = '0, mem_addr;
    logic [7:0] req_wdata = '0, rsp_rdata, dq_out, dq_in;
    logic ce_n, oe_n, we_n, dq_oe, m_drv;

    // second instance: output enable low during the write pulse
    logic b_valid = 0, b_write = 0, b_ready, b_rvalid;
    logic [14:0] b_addr = '0, b_maddr;
    logic [7:0] b_wdata = '0, b_rdata, b_dout, b_din;
    logic b_ce_n, b_oe_n, b_we_n, b_oe, b_drv;

    async_sram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
        .mem_dq_out(dq_out), .mem_dq_in(dq_in), .mem_dq_oe(dq_oe));

    sram_model #(.ACC(ACC), .HZ(TURN)) u_mem (
        .clk(clk), .addr(mem_addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .din(dq_out), .din_en(dq_oe), .dout(dq_in), .drv(m_drv));

    async_sram_ctrl #(.OE_LOW_IN_WRITE(1'b1)) uut_oelo (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
        .req_write(b_write), .req_addr(b_addr), .req_wdata(b_wdata),
        .rsp_valid(b_rvalid), .rsp_rdata(b_rdata), .mem_addr(b_maddr),
        .mem_ce_n(b_ce_n), .mem_oe_n(b_oe_n), .mem_we_n(b_we_n),
        .mem_dq_out(b_dout), .mem_dq_in(b_din), .mem_dq_oe(b_oe));

    sram_model #(.ACC(ACC), .HZ(TURN)) u_mem_b (
        .clk(clk), .addr(b_maddr), .ce_n(b_ce_n), .oe_n(b_oe_n), .we_n(b_we_n),
        .din(b_dout), .din_en(b_oe), .dout(b_din), .drv(b_drv));

    logic [7:0] shadow [int];

    function automatic logic [7:0] seed_val(logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] expect_at(logic [14:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : seed_val(a);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // ---------------- port monitors on the main instance ----------------
    int we_run = 0, ce_run = 0, oe_hi_run = 0, last_rd_start = -1000;
    bit pulse_stable = 1, pulse_oe_hi = 1, pulse_drv = 1, ce_had_we = 0, prev_dq_oe = 0;
    bit prev_rv = 0;
    logic [14:0] p_addr;
    logic [7:0] p_data;

    always @(negedge clk) if (rst_n && !done) begin
        if (!we_n) begin
            if (we_run == 0) begin
                p_addr = mem_addr; p_data = dq_out;
                pulse_stable = 1; pulse_oe_hi = 1; pulse_drv = 1;
            end else if (mem_addr != p_addr || dq_out != p_data) pulse_stable = 0;
            if (!oe_n) pulse_oe_hi = 0;
            if (!dq_oe) pulse_drv = 0;
            we_run++;
        end else if (we_run > 0) begin
            check(we_run == WPH, "R4 we_n low width", we_run, WPH);
            check(pulse_oe_hi, "R4 oe_n high during write", 0, 1);
            check(pulse_stable, "R5 addr/data stable in pulse", 0, 1);
            check(pulse_drv, "R5 data driven whole pulse", 0, 1);
            check(dq_oe && !ce_n, "R5 data and ce held after we_n rise",
                  int'(dq_oe), 1);
            we_run = 0;
        end
        if (!ce_n) begin
            if (ce_run == 0 && !oe_n) begin
                if (last_rd_start > -1000)
                    check(cyc - last_rd_start >= RCYC, "R7 read start spacing",
                          cyc - last_rd_start, RCYC);
                last_rd_start = cyc;
            end
            if (!we_n) ce_had_we = 1;
            ce_run++;
            check(!req_ready, "R2 ready low while busy", int'(req_ready), 0);
        end else if (ce_run > 0) begin
            if (ce_had_we) check(ce_run >= WCYC, "R7 write cycle length", ce_run, WCYC);
            else           check(ce_run == ACC, "R3 read access length", ce_run, ACC);
            ce_run = 0; ce_had_we = 0;
        end
        if (oe_n) oe_hi_run++; else oe_hi_run = 0;
        if (dq_oe && !prev_dq_oe)
            check(oe_hi_run - 1 >= TURN, "R6 turnaround before drive", oe_hi_run - 1, TURN);
        if (dq_oe) check(!m_drv, "R6 no bus fight", int'(m_drv), 0);
        prev_dq_oe = dq_oe;
        if (rsp_valid) begin
            check(ce_n && oe_n, "R3 strobes released with rsp_valid", int'(ce_n && oe_n), 1);
            check(!prev_rv, "R3 rsp_valid single cycle", int'(prev_rv), 0);
        end
        prev_rv = rsp_valid;
    end

    // ---------------- monitors on the output-enable-low instance ----------------
    int b_we_run = 0, b_dq_cnt = 0;
    bit b_oe_lo = 1;
    always @(negedge clk) if (rst_n && !done) begin
        if (b_oe && b_we_n) check(0, "R8 drive outside pulse", 1, 0);
        if (!b_we_n) begin
            if (b_we_run == 0) begin b_dq_cnt = 0; b_oe_lo = 1; end
            if (b_oe_n) b_oe_lo = 0;
            if (b_oe) b_dq_cnt++;
            if (b_oe && b_we_run < HIZ) check(0, "R8 drive inside hiz window", b_we_run, HIZ);
            b_we_run++;
        end else if (b_we_run > 0) begin
            check(b_we_run == WPL, "R8 oe-low pulse width", b_we_run, WPL);
            check(b_dq_cnt == WPL - HIZ, "R8 drive cycles in pulse", b_dq_cnt, WPL - HIZ);
            check(b_oe_lo, "R8 oe_n low across pulse", 0, 1);
            b_we_run = 0;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic issue(bit w, logic [14:0] a, logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        if (w) shadow[int'(a)] = d;
    endtask

    task automatic do_read(logic [14:0] a, string tag);
        logic [7:0] exp_d;
        exp_d = expect_at(a);
        issue(1'b0, a, 8'h00);
        while (!rsp_valid) @(negedge clk);
        check(rsp_rdata == exp_d, tag, rsp_rdata, exp_d);
    endtask

    task automatic issue_b(bit w, logic [14:0] a, logic [7:0] d);
        @(negedge clk);
        while (!b_ready) @(negedge clk);
        b_valid = 1; b_write = w; b_addr = a; b_wdata = d;
        @(negedge clk);
        b_valid = 0;
    endtask

    task automatic read_b(logic [14:0] a, logic [7:0] exp_d);
        issue_b(1'b0, a, 8'h00);
        while (!b_rvalid) @(negedge clk);
        check(b_rdata == exp_d, "R8 oe-low mode readback", b_rdata, exp_d);
    endtask

    initial begin
        int seed_dummy;
        logic [7:0] held;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: reset state while held
        check(req_ready && ce_n && oe_n && we_n && !dq_oe && !rsp_valid,
              "R1 reset outputs", int'({req_ready, ce_n, oe_n, we_n, dq_oe, rsp_valid}), 6'b111100);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && ce_n && oe_n && we_n && !dq_oe && !rsp_valid,
              "R1 first cycle after reset", int'({req_ready, ce_n, oe_n, we_n, dq_oe, rsp_valid}), 6'b111100);

        // R10: address corners and untouched content
        do_read(15'h1234, "R10 unwritten location");
        issue(1'b1, 15'h0000, 8'hA5);
        issue(1'b1, 15'h7FFF, 8'h3C);
        do_read(15'h7FFF, "R10 top address readback");
        do_read(15'h0000, "R10 bottom address readback");

        // R6: write immediately after read
        do_read(15'h0000, "R3 read before turnaround write");
        issue(1'b1, 15'h0040, 8'h77);
        do_read(15'h0040, "R6 write after read stored");

        // R2: request inputs wiggled while busy are ignored
        issue(1'b1, 15'h0101, 8'h11);
        begin
            logic [14:0] a_seen;
            a_seen = mem_addr;
            while (!req_ready) begin
                req_valid = 1; req_write = 1; req_addr = 15'h0202; req_wdata = 8'hFF;
                check(mem_addr == 15'h0101, "R2 address held while busy", mem_addr, 15'h0101);
                @(negedge clk);
            end
            req_valid = 0;
            check(a_seen == 15'h0101, "R2 accepted address", a_seen, 15'h0101);
        end
        do_read(15'h0101, "R2 busy inputs ignored (data)");
        do_read(15'h0202, "R2 busy inputs ignored (other address)");

        // R9: read data held across a later write
        do_read(15'h0040, "R9 setup read");
        held = rsp_rdata;
        issue(1'b1, 15'h0041, 8'h99);
        repeat (8) @(negedge clk);
        check(rsp_rdata == held, "R9 rdata held", rsp_rdata, held);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [14:0] a;
            a = ($urandom_range(0, 1) == 0) ? 15'($urandom_range(0, 31)) : 15'($urandom);
            if ($urandom_range(0, 1) == 0) issue(1'b1, a, 8'($urandom));
            else do_read(a, "R10 random readback");
        end

        // R8: second instance with output enable low during the pulse
        issue_b(1'b1, 15'h0123, 8'hC3);
        issue_b(1'b1, 15'h7FFF, 8'h18);
        read_b(15'h0123, 8'hC3);
        issue_b(1'b1, 15'h0124, 8'h42);
        read_b(15'h7FFF, 8'h18);
        read_b(15'h0124, 8'h42);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule